// File: doc/BRIEF.md
# Digital Second-Trim Calibrator

This block trims the one-second tick derived from a 32.768 kHz oscillator without any analog trim parts. The oscillator rate arrives as a clock enable. A prescaler divides it by 256 into a 128 Hz stage, and a second counter divides that stage into seconds. To pull the timebase faster or slower, the block changes the length of chosen seconds by a fixed number of oscillator cycles. For a slower clock it stalls the stage for an extra half period, which blanks pulses. For a faster clock it lets one stage pulse count twice, which splits pulses.

The chosen seconds follow a repeating cycle of 64 minutes. An external minute strobe marks where each minute starts. A 5-bit magnitude N and a direction bit set the trim. The first second of each of the first 2N minutes in the cycle is modified, so with N at 31 the last two minutes of the cycle are never touched. A frequency-test output is taken from a free-running tap ahead of the correction. It stays at exactly 512 Hz whatever trim is loaded.

Top module: `pcc_trim`

## Requirements
- R1: While reset is active, `sec_tick` and `ft_out` are 0, and the minute position returns to 0, so the first minute strobe after reset starts minute 0 of the cycle.
- R2: An unmodified second lasts PRE_DIV*STG_PER_SEC enabled oscillator cycles (32768 by default). `sec_tick` is high in the last enabled cycle of each second.
- R3: A modified second with `cal_pos`=0 (slow down) lasts PRE_DIV/2 enabled cycles longer than nominal (+128 by default).
- R4: A modified second with `cal_pos`=1 (speed up) lasts PRE_DIV enabled cycles shorter than nominal (-256 by default).
- R5: The minute with cycle index k (0..63) has its first second modified if and only if k < 2*`cal_mag`. With a magnitude of 0, no second is modified, and minutes 62 and 63 are never modified.
- R6: Each `min_stb` pulse advances the minute index by one. After index 63 the index wraps to 0.
- R7: `cal_mag` and `cal_pos` are sampled only in a cycle where `min_stb` is high. A change between strobes does not alter any second until the next strobe.
- R8: When `min_stb` is high in the same cycle as `sec_tick`, the second that starts on the next cycle is the first second of the minute. When a strobe falls inside a second, that second keeps its length and the next full second is the first second of the minute. Exactly one second per selected minute is modified.
- R9: Counting advances only in cycles where `osc_en` is high, and `sec_tick` is never high while `osc_en` is low.
- R10: `ft_out` toggles once every PRE_DIV/8 enabled cycles (512 Hz at 32.768 kHz), including during modified seconds.
- R11: `sec_tick` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_en | input | 1 | One-cycle enable per oscillator period |
| min_stb | input | 1 | Minute boundary strobe; samples the trim setting |
| cal_mag | input | 5 | Trim magnitude N, 0 to 31 |
| cal_pos | input | 1 | Trim direction: 1 speeds up, 0 slows down |
| sec_tick | output | 1 | Corrected one-second pulse |
| ft_out | output | 1 | Uncorrected 512 Hz frequency-test square wave |

## Verification
The sharpest overlap is a minute strobe arriving in the same cycle as the end of a second. In that cycle the block must both advance the minute index and decide the length of the second that begins on the next cycle. The bench provokes this by raising the strobe in the exact cycle where the tick is observed. It then judges the outcome by counting enabled cycles up to the following tick, and compares the count with the length predicted from the minute index and trim setting. The mid-second strobe case is run as a contrast: the running second must keep its nominal length and the correction must move to the next second. The frequency-test output is measured throughout, including during these modified seconds.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int MAG_W = 5;
  localparam int MIN_W = 6;

  typedef struct packed {
    logic sel;
    logic pos;
  } corr_t;
endpackage

// File: rtl/pcc_minute_sel.sv
module pcc_minute_sel
  import pcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             min_stb,
  input  logic             sec_edge,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  output logic             mod_neg,
  output logic             mod_pos
);
  localparam int CMP_W = (MIN_W > MAG_W + 1) ? MIN_W : MAG_W + 1;

  logic [MIN_W-1:0] min_cnt_q, min_cnt_d;
  logic             pend_q, pend_d;
  corr_t            pend_c_q, pend_c_d;
  corr_t            mod_q, mod_d;
  corr_t            now_c;
  logic             sel_now;

  // minute index below twice the magnitude selects this minute
  assign sel_now   = (CMP_W'(min_cnt_q) < CMP_W'({cal_mag, 1'b0}));
  assign now_c.sel = sel_now;
  assign now_c.pos = cal_pos;

  always_comb begin
    min_cnt_d = min_cnt_q;
    pend_d    = pend_q;
    pend_c_d  = pend_c_q;
    mod_d     = mod_q;
    if (min_stb) begin
      min_cnt_d = min_cnt_q + 1'b1;
    end
    if (sec_edge) begin
      pend_d = 1'b0;
      if (min_stb) begin
        mod_d = now_c;
      end else if (pend_q) begin
        mod_d = pend_c_q;
      end else begin
        mod_d = '0;
      end
    end else if (min_stb) begin
      pend_d   = 1'b1;
      pend_c_d = now_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_cnt_q <= '0;
      pend_q    <= 1'b0;
      pend_c_q  <= '0;
      mod_q     <= '0;
    end else begin
      min_cnt_q <= min_cnt_d;
      pend_q    <= pend_d;
      pend_c_q  <= pend_c_d;
      mod_q     <= mod_d;
    end
  end

  assign mod_neg = mod_q.sel & ~mod_q.pos;
  assign mod_pos = mod_q.sel &  mod_q.pos;

  AST_MIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (min_stb && min_cnt_q == '1) |=> (min_cnt_q == '0)); // R6
  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !min_stb |=> $stable(min_cnt_q)); // R6
  AST_SEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (min_stb && !sec_edge && min_cnt_q >= MIN_W'(62)) |=> !pend_c_q.sel); // R5
  AST_MOD_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_edge |=> ($stable(mod_neg) && $stable(mod_pos))); // R8
endmodule

// File: rtl/pcc_divider.sv
module pcc_divider #(
  parameter int PRE_DIV     = 256,
  parameter int STG_PER_SEC = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic mod_neg,
  input  logic mod_pos,
  output logic sec_edge
);
  localparam int PRE_W   = $clog2(PRE_DIV + PRE_DIV / 2);
  localparam int STG_W   = $clog2(STG_PER_SEC);
  localparam int LIM_NOM = PRE_DIV - 1;
  localparam int LIM_EXT = PRE_DIV + PRE_DIV / 2 - 1;

  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [STG_W-1:0] stg_q, stg_d, stg_lim;
  logic             pre_hit, stg_hit;

  // blanking: first stage period of a slowed second runs half a period longer
  assign pre_lim = (mod_neg && stg_q == '0) ? PRE_W'(LIM_EXT) : PRE_W'(LIM_NOM);
  // splitting: a sped-up second ends one stage pulse early
  assign stg_lim = mod_pos ? STG_W'(STG_PER_SEC - 2) : STG_W'(STG_PER_SEC - 1);

  assign pre_hit  = (pre_q == pre_lim);
  assign stg_hit  = (stg_q == stg_lim);
  assign sec_edge = osc_en & pre_hit & stg_hit;

  always_comb begin
    pre_d = pre_q;
    stg_d = stg_q;
    if (osc_en) begin
      if (pre_hit) begin
        pre_d = '0;
        stg_d = stg_hit ? '0 : stg_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      stg_q <= '0;
    end else begin
      pre_q <= pre_d;
      stg_q <= stg_d;
    end
  end

  AST_GATED_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> ($stable(pre_q) && $stable(stg_q))); // R9
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_edge |=> !sec_edge); // R11
  AST_NO_DUAL_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_neg && mod_pos)); // R3
endmodule

// File: rtl/pcc_test_tap.sv
module pcc_test_tap #(
  parameter int PRE_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  output logic ft_out
);
  localparam int TAP = $clog2(PRE_DIV) - 3;

  logic [TAP:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (osc_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ft_out = cnt_q[TAP];

  AST_FT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> $stable(ft_out)); // R10
endmodule

// File: rtl/pcc_trim.sv
module pcc_trim
  import pcc_pkg::*;
#(
  parameter int PRE_DIV     = 256,
  parameter int STG_PER_SEC = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             min_stb,
  input  logic [MAG_W-1:0] cal_mag,
  input  logic             cal_pos,
  output logic             sec_tick,
  output logic             ft_out
);
  logic mod_neg, mod_pos, sec_edge;

  pcc_minute_sel u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .min_stb  (min_stb),
    .sec_edge (sec_edge),
    .cal_mag  (cal_mag),
    .cal_pos  (cal_pos),
    .mod_neg  (mod_neg),
    .mod_pos  (mod_pos)
  );

  pcc_divider #(.PRE_DIV(PRE_DIV), .STG_PER_SEC(STG_PER_SEC)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .mod_neg  (mod_neg),
    .mod_pos  (mod_pos),
    .sec_edge (sec_edge)
  );

  pcc_test_tap #(.PRE_DIV(PRE_DIV)) u_tap (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .ft_out (ft_out)
  );

  assign sec_tick = sec_edge;
endmodule

// File: tb/pcc_trim_test.sv
`timescale 1ns/1ps
module pcc_trim_test;
  localparam int PRE = 16;
  localparam int STG = 8;
  localparam int NOM = PRE * STG;
  localparam int NEG = NOM + PRE / 2;
  localparam int POS = NOM - PRE;
  localparam int FTH = PRE / 8;

  logic       clk = 1'b0;
  logic       rst_n, osc_en, min_stb, cal_pos;
  logic [4:0] cal_mag;
  logic       sec_tick, ft_out;

  always #2 clk = ~clk;

  pcc_trim #(.PRE_DIV(PRE), .STG_PER_SEC(STG)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .min_stb(min_stb),
    .cal_mag(cal_mag), .cal_pos(cal_pos), .sec_tick(sec_tick), .ft_out(ft_out)
  );

  int    checks = 0, fails = 0;
  int    exp_q[$];
  string tag_q[$];
  int    m_model = 0, cur_mag = 0;
  bit    cur_pos = 0, pend_v = 0;
  int    pend_len = 0;
  bit    done = 0, mon_on = 0;
  int    len_cnt = 0, ft_cnt = 0;
  logic  ft_last = 1'b0, tick_last = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_len();
    if (m_model < 2 * cur_mag) return cur_pos ? POS : NEG;
    return NOM;
  endfunction

  // monitor: pops expected second lengths and compares
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (!osc_en) chk("R9 tick while disabled", int'(sec_tick), 0);
      if (osc_en) len_cnt++;
      if (sec_tick) begin
        chk("R11 pulse width", int'(tick_last), 0);
        if (exp_q.size() == 0) chk("scoreboard empty", 1, 0);
        else chk({tag_q.pop_front(), " second length"}, len_cnt, exp_q.pop_front());
        len_cnt = 0;
      end
      tick_last = sec_tick;
      if (ft_out != ft_last) begin
        chk("R10 ft half period", ft_cnt, FTH);
        ft_cnt  = 0;
        ft_last = ft_out;
      end
      if (osc_en) ft_cnt++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_tick();
    do step(); while (!sec_tick);
  endtask

  task automatic set_cal(input int mag, input bit pos);
    cal_mag = 5'(mag); cal_pos = pos; cur_mag = mag; cur_pos = pos;
  endtask

  // driver: at a tick, optionally strobe and push the next second's length
  task automatic next_sec(input bit stb, input string tag);
    int len;
    wait_tick();
    if (stb) begin
      min_stb = 1'b1;
      len     = model_len();
      m_model = (m_model + 1) % 64;
      pend_v  = 0;
    end else if (pend_v) begin
      len    = pend_len;
      pend_v = 0;
    end else begin
      len = NOM;
    end
    exp_q.push_back(len);
    tag_q.push_back(tag);
    step();
    min_stb = 1'b0;
  endtask

  task automatic mid_strobe(input int cyc);
    repeat (cyc) step();
    min_stb  = 1'b1;
    pend_len = model_len();
    pend_v   = 1;
    m_model  = (m_model + 1) % 64;
    step();
    min_stb = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; osc_en = 1'b0; min_stb = 1'b0;
    set_cal(0, 0);
    repeat (3) step();
    osc_en = 1'b1;
    repeat (4) step();
    chk("R1 reset tick", int'(sec_tick), 0);
    chk("R1 reset ft", int'(ft_out), 0);
    exp_q.push_back(NOM); tag_q.push_back("R2");
    rst_n  = 1'b1;
    mon_on = 1;

    // R2: zero magnitude
    next_sec(1, "R2"); next_sec(1, "R2");
    // R3 and R5: slow down, N=2 covers minutes 0..3
    set_cal(2, 0);
    next_sec(1, "R3"); next_sec(1, "R3");
    next_sec(1, "R5"); next_sec(1, "R5");
    // R4 and R5: speed up, N=4 covers minutes 0..7
    set_cal(4, 1);
    next_sec(1, "R4"); next_sec(1, "R4");
    next_sec(1, "R5");
    // R7: change between strobes has no effect
    set_cal(0, 0);
    next_sec(1, "R7");
    repeat (30) step();
    set_cal(31, 1);
    next_sec(0, "R7"); next_sec(0, "R7");
    // R8: strobe inside a second moves correction to the next second
    mid_strobe(20);
    next_sec(0, "R8"); next_sec(0, "R8");
    // R9: gaps in the oscillator enable
    set_cal(0, 0);
    next_sec(1, "R9");
    for (int i = 0; i < 10; i++) begin
      osc_en = 1'b0; repeat (3) step();
      osc_en = 1'b1; step();
    end
    next_sec(0, "R9");
    // R5 limit at N=31 and R6 wrap
    set_cal(31, 0);
    while (m_model != 60) next_sec(1, "R5");
    for (int i = 0; i < 4; i++) next_sec(1, "R5");
    set_cal(1, 0);
    for (int i = 0; i < 3; i++) next_sec(1, "R6");
    wait_tick();
    step();
    finish_run();
  end
endmodule